// File: doc/BRIEF.md
# Recovered-Clock Lock Status Detector

This block decides whether a clock-recovery loop is locked by looking at samples of its recovered clock. The samples are taken by a separate sample clock that runs at the line rate. A locked loop keeps the sampled recovered clock low. A loop that is drifting shows high samples from time to time.

The block declares lock quickly and unlock slowly. A single unbroken run of low samples is enough to declare lock. Unlock is declared only when the high samples are too many in every one of several frames in a row. Each frame is a fixed number of sample clocks. In every other case the last decision is kept.

The unlock flag is active high and is forced high during reset. Each time it rises, the block also gives a one-cycle recalibration request. The sample clock is independent of the recovered clock, so the flag has no timing relation to the recovered clock.

Top module: `lock_status_detector`

## Requirements
- R1: After 32 consecutive low samples of `rclk_smp_i`, `unlock_o` goes low at the clock edge that takes the 32nd low sample. It does not go low after only 31 low samples.
- R2: Any high sample clears the run of consecutive low samples. Counting for lock then starts again from zero.
- R3: A frame is 256 consecutive samples. A frame is bad only when more than 5 of its samples are high. A frame with exactly 5 high samples is good.
- R4: `unlock_o` goes high at the edge that takes the last sample of the 5th bad frame in a row. It does not go high after only 4 bad frames in a row. A good frame clears the count of bad frames.
- R5: When neither the lock condition nor the unlock condition is met, `unlock_o` keeps its value. This holds both while locked and while unlocked.
- R6: While `rst_n` is low, `unlock_o` is 1 (unlocked) and `recal_o` is 0.
- R7: `recal_o` is high for exactly one cycle, in the cycle where `unlock_o` has just risen from 0 to 1. It stays low while `unlock_o` stays high, and it gives no pulse when reset is released.
- R8: Frame counting restarts when reset is released. A partial frame seen before a reset does not shift where later frames begin.
- R9: Reset is applied asynchronously and released through a two-stage synchronizer. The first sample that counts is the one taken at the third rising edge of `clk_smp` after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sample clock at the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rclk_smp_i | input | 1 | Recovered-clock bit as sampled on `clk_smp` |
| unlock_o | output | 1 | 1 = unlocked, 0 = locked |
| recal_o | output | 1 | One-cycle request for recalibration, given when `unlock_o` rises |

## Verification
The bench uses five kinds of input pattern:

- **All low.** This finds the exact sample on which lock is declared.
- **A run of 31 low samples cut by one high sample.** This shows that the low-run counter clears and does not just pause.
- **Frames with a high sample every 16 positions.** Each such frame has 16 high samples and never reaches 32 low samples in a row. It is a bad frame that cannot cause lock. It pins down the exact edge of unlock and the single recalibration pulse.
- **Frames with exactly five high samples.** These sit on the limit, so they test the bad-frame threshold. A frame of this kind placed among bad frames shows that the bad-frame count is cleared.
- **A reset in the middle of a frame.** This shows that the frame boundaries restart from the release of reset.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
package lsd_pkg;
  typedef enum logic {
    ST_LOCKED   = 1'b0,
    ST_UNLOCKED = 1'b1
  } lsd_state_e;
endpackage

// File: rtl/lsd_rst_sync.sv
`timescale 1ns/1ps
module lsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lsd_low_run.sv
`timescale 1ns/1ps
module lsd_low_run #(
  parameter int LOCK_RUN = 32
) (
  input  logic clk,
  input  logic srst_n,
  input  logic smp_i,
  output logic lock_hit_o
);
  localparam int CW = $clog2(LOCK_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(LOCK_RUN);
  localparam logic [CW-1:0] RUN_TRIG = CW'(LOCK_RUN - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // next state: a high sample restarts the run, a low one extends it up to saturation
  always_comb begin
    run_d = run_q;
    if (smp_i)                run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) run_q <= '0;
    else         run_q <= run_d;
  end

  assign lock_hit_o = !smp_i && (run_q >= RUN_TRIG);

  // R2: a high sample leaves the run counter empty on the next cycle
  a_r2_high_clears_run: assert property (@(posedge clk) disable iff (!srst_n)
    smp_i |=> (run_q == '0));

  a_r1_run_bounded: assert property (@(posedge clk) disable iff (!srst_n)
    run_q <= RUN_MAX);
endmodule

// File: rtl/lsd_frame_mon.sv
`timescale 1ns/1ps
module lsd_frame_mon #(
  parameter int FRAME_LEN  = 256,
  parameter int HIGH_LIMIT = 5,
  parameter int BAD_FRAMES = 5
) (
  input  logic clk,
  input  logic srst_n,
  input  logic smp_i,
  output logic frame_end_o,
  output logic unlock_hit_o
);
  localparam int PW = $clog2(FRAME_LEN);
  localparam int HW = $clog2(HIGH_LIMIT + 2);
  localparam int BW = $clog2(BAD_FRAMES + 1);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_LEN - 1);
  localparam logic [HW-1:0] HI_LIM   = HW'(HIGH_LIMIT);
  localparam logic [HW-1:0] HI_SAT   = HW'(HIGH_LIMIT + 1);
  localparam logic [BW-1:0] BAD_SAT  = BW'(BAD_FRAMES);
  localparam logic [BW-1:0] BAD_TRIG = BW'(BAD_FRAMES - 1);

  logic [PW-1:0] pos_q, pos_d;
  logic [HW-1:0] hi_q, hi_d, hi_sum;
  logic [BW-1:0] bad_q, bad_d;
  logic          frame_bad;

  assign frame_end_o = (pos_q == POS_LAST);

  // count high samples of the current frame, saturating one above the limit
  always_comb begin
    if (hi_q == HI_SAT) hi_sum = hi_q;
    else                hi_sum = hi_q + {{(HW-1){1'b0}}, smp_i};
    frame_bad = (hi_sum > HI_LIM);
  end

  always_comb begin
    pos_d = frame_end_o ? '0 : pos_q + PW'(1);
    hi_d  = frame_end_o ? '0 : hi_sum;
    bad_d = bad_q;
    if (frame_end_o) begin
      if (!frame_bad)            bad_d = '0;
      else if (bad_q != BAD_SAT) bad_d = bad_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pos_q <= '0;
      hi_q  <= '0;
      bad_q <= '0;
    end else begin
      pos_q <= pos_d;
      hi_q  <= hi_d;
      bad_q <= bad_d;
    end
  end

  assign unlock_hit_o = frame_end_o && frame_bad && (bad_q >= BAD_TRIG);

  // R3: frame position wraps to zero after the last sample
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!srst_n)
    frame_end_o |=> (pos_q == '0));

  a_r3_high_count_bounded: assert property (@(posedge clk) disable iff (!srst_n)
    hi_q <= HI_SAT);

  // R4: the bad-frame counter never moves except on a frame boundary
  a_r4_bad_run_stable: assert property (@(posedge clk) disable iff (!srst_n)
    !frame_end_o |=> $stable(bad_q));
endmodule

// File: rtl/lock_status_detector.sv
`timescale 1ns/1ps
module lock_status_detector #(
  parameter int LOCK_RUN    = 32,
  parameter int FRAME_LEN   = 256,
  parameter int HIGH_LIMIT  = 5,
  parameter int BAD_FRAMES  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_smp,
  input  logic rst_n,
  input  logic rclk_smp_i,
  output logic unlock_o,
  output logic recal_o
);
  import lsd_pkg::*;

  logic       srst_n;
  logic       lock_hit;
  logic       unlock_hit;
  logic       frame_end;
  lsd_state_e state_q, state_d;
  logic       recal_q, recal_d;

  lsd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk_smp),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lsd_low_run #(.LOCK_RUN(LOCK_RUN)) u_low_run (
    .clk        (clk_smp),
    .srst_n     (srst_n),
    .smp_i      (rclk_smp_i),
    .lock_hit_o (lock_hit)
  );

  lsd_frame_mon #(
    .FRAME_LEN  (FRAME_LEN),
    .HIGH_LIMIT (HIGH_LIMIT),
    .BAD_FRAMES (BAD_FRAMES)
  ) u_frame_mon (
    .clk          (clk_smp),
    .srst_n       (srst_n),
    .smp_i        (rclk_smp_i),
    .frame_end_o  (frame_end),
    .unlock_hit_o (unlock_hit)
  );

  // next state: unlock wins a tie, otherwise hold
  always_comb begin
    state_d = state_q;
    if (unlock_hit)    state_d = ST_UNLOCKED;
    else if (lock_hit) state_d = ST_LOCKED;
    recal_d = (state_d == ST_UNLOCKED) && (state_q == ST_LOCKED);
  end

  always_ff @(posedge clk_smp or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_UNLOCKED;
      recal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      recal_q <= recal_d;
    end
  end

  assign unlock_o = (state_q == ST_UNLOCKED);
  assign recal_o  = recal_q;

  // R1: lock is only taken on a low sample
  a_r1_lock_on_low: assert property (@(posedge clk_smp) disable iff (!srst_n)
    $fell(unlock_o) |-> $past(!rclk_smp_i));

  // R4: unlock only rises on a frame boundary
  a_r4_unlock_at_frame_end: assert property (@(posedge clk_smp) disable iff (!srst_n)
    $rose(unlock_o) |-> $past(frame_end));

  // R7: a recalibration request lasts one cycle and comes with unlock
  a_r7_recal_single: assert property (@(posedge clk_smp) disable iff (!srst_n)
    recal_o |=> !recal_o);

  a_r7_recal_with_unlock: assert property (@(posedge clk_smp) disable iff (!srst_n)
    recal_o |-> unlock_o);
endmodule

// File: tb/lock_status_detector_tb_top.sv
`timescale 1ns/1ps
module lock_status_detector_tb_top;
  logic clk_smp = 1'b0;
  logic rst_n;
  logic rclk_smp_i;
  logic unlock_o;
  logic recal_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk_smp = ~clk_smp;

  lock_status_detector dut_i (
    .clk_smp    (clk_smp),
    .rst_n      (rst_n),
    .rclk_smp_i (rclk_smp_i),
    .unlock_o   (unlock_o),
    .recal_o    (recal_o)
  );

  task automatic check(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // drive one sample, let it be taken, then settle away from the edge
  task automatic step(input logic v);
    rclk_smp_i = v;
    @(posedge clk_smp);
    #2;
  endtask

  // kind 0: all low; 1: high every 16th position (16 highs); 2: exactly 5 highs
  task automatic run_frame(input int kind, input int count);
    for (int p = 0; p < count; p++) begin
      logic v;
      case (kind)
        1:       v = ((p % 16) == 0);
        2:       v = ((p % 51) == 0) && (p != 255);
        default: v = 1'b0;
      endcase
      step(v);
    end
  endtask

  task automatic do_reset();
    rclk_smp_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk_smp);
    #2;
    rst_n = 1'b1;
    repeat (2) @(posedge clk_smp);
    #2;
  endtask

  task automatic t_reset_state();
    rclk_smp_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk_smp);
    #2;
    check(unlock_o, 1'b1, "R6 unlock during reset");
    check(recal_o, 1'b0, "R6 recal during reset");
    rst_n = 1'b1;
    repeat (2) @(posedge clk_smp);
    #2;
    check(recal_o, 1'b0, "R7 no pulse at reset release");
  endtask

  task automatic t_lock_run();
    do_reset();
    run_frame(0, 31);
    check(unlock_o, 1'b1, "R1 still unlocked after 31 lows");
    step(1'b0);
    check(unlock_o, 1'b0, "R1 locked after 32 lows");
    check(recal_o, 1'b0, "R7 no pulse on lock");
  endtask

  task automatic t_run_break();
    do_reset();
    run_frame(0, 31);
    step(1'b1);
    run_frame(0, 31);
    check(unlock_o, 1'b1, "R2 run restarted by high sample");
    step(1'b0);
    check(unlock_o, 1'b0, "R2 lock after fresh run of 32");
  endtask

  task automatic t_unlock_seq();
    do_reset();
    run_frame(1, 100);
    do_reset();
    check(unlock_o, 1'b1, "R8 unlocked after mid-frame reset");
    run_frame(0, 256);
    check(unlock_o, 1'b0, "R9 locked in first frame after release");
    for (int f = 0; f < 4; f++) run_frame(1, 256);
    check(unlock_o, 1'b0, "R4 held locked after 4 bad frames");
    run_frame(1, 255);
    check(unlock_o, 1'b0, "R8 not unlocked before frame end");
    step(1'b0);
    check(unlock_o, 1'b1, "R4 unlocked at end of 5th bad frame");
    check(recal_o, 1'b1, "R7 recal pulse on unlock");
    step(1'b1);
    check(recal_o, 1'b0, "R7 recal lasts one cycle");
    check(unlock_o, 1'b1, "R5 unlock held");
  endtask

  task automatic t_hold_unlocked();
    logic seen;
    seen = 1'b0;
    run_frame(1, 255);
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < 256; p++) begin
        step((p % 16) == 0);
        if (recal_o) seen = 1'b1;
      end
    end
    check(unlock_o, 1'b1, "R5 stays unlocked with short low runs");
    check(seen, 1'b0, "R7 no repeat pulse while unlocked");
  endtask

  task automatic t_exact_limit();
    do_reset();
    run_frame(0, 256);
    for (int f = 0; f < 6; f++) begin
      run_frame(2, 256);
      check(unlock_o, 1'b0, "R3 five highs per frame is a good frame");
    end
  endtask

  task automatic t_good_clears();
    do_reset();
    run_frame(0, 256);
    for (int f = 0; f < 4; f++) run_frame(1, 256);
    run_frame(2, 256);
    for (int f = 0; f < 4; f++) run_frame(1, 256);
    check(unlock_o, 1'b0, "R4 good frame cleared bad-frame count");
    run_frame(1, 256);
    check(unlock_o, 1'b1, "R4 unlock after 5 fresh bad frames");
  endtask

  initial begin
    rclk_smp_i = 1'b0;
    rst_n = 1'b0;
    t_reset_state();
    t_lock_run();
    t_run_break();
    t_unlock_seq();
    t_hold_unlocked();
    t_exact_limit();
    t_good_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule